// File: doc/BRIEF.md
# Banked Differential Gamma Lookup Engine

This block applies gamma correction to a stream of RGB pixels, one table lookup for each colour channel. The table holds 1024 entries per channel. Software loads it through a single-cycle write strobe that carries a byte offset and a data word. The table is reached through windows of 256 entries. A bank register chooses which quarter of the table the windows address, and it also chooses how a written word is laid out. In the packed layout one word carries all three channels at 10 bits each. In the split layout one word carries red and green at 12 bits each, and blue at 12 bits goes through a second window.

Entries are stored in pairs. An even entry holds an absolute output value. The odd entry after it holds an increment, and the lookup adds that increment to its even neighbour. Each pixel component uses its upper bits as the table index. The lookup pipeline has two register stages and one shared stall, so a result leaves the block two cycles after the pixel is accepted, provided the consumer keeps taking data.

Top module: `gamma_lut_engine`

## Requirements
- R1: After reset, out_valid is low and in_ready is high. The active bank is 0 and the packed 10-bit layout is selected.
- R2: A write to byte offset 0x100 loads the bank register. Bits [1:0] of the data select the bank and bit 2 selects the split 12-bit layout when it is 1. A table write to window slot i (offset = window base + 4*i, i from 0 to 255) updates table entry bank*256 + i.
- R3: In the packed layout, a write at the first window (base 0x700) sets red from data bits [29:20], green from [19:10] and blue from [9:0]. Each value is output left-aligned on the 12-bit result with bits [1:0] equal to zero.
- R4: In the split layout, a write at the first window sets red from bits [11:0] and green from bits [23:12] and leaves blue unchanged. A write at the second window (base 0xB00) sets blue from bits [11:0] and leaves red and green unchanged.
- R5: In the packed layout, a write at the second window changes no table entry.
- R6: The table index of a component is its upper 10 bits (in_x[11:2]). An even index returns the stored value of that entry.
- R7: An odd index k returns the sum of the stored values of entries k-1 and k, taken modulo 4096.
- R8: A pixel accepted in cycle n (in_valid and in_ready high) appears with out_valid high in cycle n+2 when out_ready stays high. Results leave in acceptance order.
- R9: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, the output pixel and out_valid hold.
- R10: When a table write and a pixel acceptance fall in the same cycle and address the same entry, the pixel returns the value held before the write.
- R11: Writes to any other offset, and writes to a window or bank offset whose bits [1:0] are not zero, change neither the table nor the bank register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 32 | Write data word |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take an input pixel this cycle |
| in_r | input | 12 | Input red component |
| in_g | input | 12 | Input green component |
| in_b | input | 12 | Input blue component |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the output pixel this cycle |
| out_r | output | 12 | Corrected red |
| out_g | output | 12 | Corrected green |
| out_b | output | 12 | Corrected blue |

## Verification
The bench builds the block with its default parameters: 12-bit components, a 10-bit index, 256-entry banks, 10-bit packed and 12-bit split layouts, and difference coding enabled. With these values every bank can be reached, including entry 1023 at the top of the last bank and slot 255 at the top of each window. The 12-bit increment sum can overflow its range, and switching layouts in the middle of a run shows that entries written earlier keep their values. The variant with difference coding disabled is a generate option that this bench does not build.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
   localparam int NUM_CH = 3;
   localparam int CH_R   = 0;
   localparam int CH_G   = 1;
   localparam int CH_B   = 2;

   localparam int unsigned BANK_REG_OFS = 32'h0000_0100;
   localparam int unsigned PRI_WIN_OFS  = 32'h0000_0700;
   localparam int unsigned SEC_WIN_OFS  = 32'h0000_0B00;

   typedef enum logic {
      FMT_PACKED = 1'b0,
      FMT_SPLIT  = 1'b1
   } lut_fmt_e;
endpackage

// File: rtl/gamma_lut_regs.sv
module gamma_lut_regs
   import gamma_lut_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 32,
   parameter int IDX_W        = 10,
   parameter int BANK_ENTRIES = 256,
   parameter int WIDE_W       = 12,
   parameter int NARROW_W     = 10
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [NUM_CH-1:0]              tab_we,
   output logic [IDX_W-1:0]               tab_addr,
   output logic [NUM_CH-1:0][WIDE_W-1:0]  tab_val
);
   localparam int OFS_W     = $clog2(BANK_ENTRIES);
   localparam int BANK_W    = IDX_W - OFS_W;
   localparam int WIN_BYTES = BANK_ENTRIES * 4;
   localparam int PAD_W     = WIDE_W - NARROW_W;

   logic [BANK_W-1:0] bank_q;
   lut_fmt_e          fmt_q;

   logic [31:0]      addr32;
   logic             word_ok;
   logic             hit_bank;
   logic             hit_pri;
   logic             hit_sec;
   logic [OFS_W-1:0] pri_slot;
   logic [OFS_W-1:0] sec_slot;

   assign addr32   = 32'(wr_addr);
   assign word_ok  = (wr_addr[1:0] == 2'b00);
   assign hit_bank = wr_en && (addr32 == BANK_REG_OFS);
   assign hit_pri  = wr_en && word_ok && (addr32 >= PRI_WIN_OFS) &&
                     (addr32 < PRI_WIN_OFS + WIN_BYTES);
   assign hit_sec  = wr_en && word_ok && (addr32 >= SEC_WIN_OFS) &&
                     (addr32 < SEC_WIN_OFS + WIN_BYTES);
   assign pri_slot = OFS_W'((addr32 - PRI_WIN_OFS) >> 2);
   assign sec_slot = OFS_W'((addr32 - SEC_WIN_OFS) >> 2);
   assign tab_addr = {bank_q, (hit_sec ? sec_slot : pri_slot)};

   // bank register: bank select in the low bits, layout select just above
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         fmt_q  <= FMT_PACKED;
      end else if (hit_bank) begin
         bank_q <= wr_data[BANK_W-1:0];
         fmt_q  <= lut_fmt_e'(wr_data[BANK_W]);
      end
   end

   // per-channel field extraction for both layouts
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [NARROW_W-1:0] narrow_fld;
      logic [WIDE_W-1:0]   wide_fld;
      logic                wide_we;

      assign narrow_fld = wr_data[(NUM_CH-1-ch)*NARROW_W +: NARROW_W];

      if (ch == CH_B) begin : g_sec
         assign wide_fld = wr_data[0 +: WIDE_W];
         assign wide_we  = hit_sec;
      end else begin : g_pri
         assign wide_fld = wr_data[ch*WIDE_W +: WIDE_W];
         assign wide_we  = hit_pri;
      end

      assign tab_val[ch] = (fmt_q == FMT_SPLIT) ? wide_fld
                                                : {narrow_fld, {PAD_W{1'b0}}};
      assign tab_we[ch]  = (fmt_q == FMT_SPLIT) ? wide_we : hit_pri;
   end

   logic unused_data;
   assign unused_data = ^wr_data;
endmodule

// File: rtl/gamma_lut_store.sv
module gamma_lut_store
   import gamma_lut_pkg::*;
#(
   parameter int IDX_W  = 10,
   parameter int WIDE_W = 12
) (
   input  logic                          clk,
   input  logic [NUM_CH-1:0]             tab_we,
   input  logic [IDX_W-1:0]              tab_addr,
   input  logic [NUM_CH-1:0][WIDE_W-1:0] tab_val,
   input  logic [NUM_CH-1:0][IDX_W-2:0]  rd_pair,
   output logic [NUM_CH-1:0][WIDE_W-1:0] rd_even,
   output logic [NUM_CH-1:0][WIDE_W-1:0] rd_odd
);
   localparam int PAIR_W = IDX_W - 1;
   localparam int PAIRS  = 1 << PAIR_W;

   logic [PAIR_W-1:0] wr_pair;
   logic              wr_odd;

   assign wr_pair = tab_addr[IDX_W-1:1];
   assign wr_odd  = tab_addr[0];

   // even and odd halves kept apart so one cycle reads both halves of a pair
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [WIDE_W-1:0] even_mem [PAIRS];
      logic [WIDE_W-1:0] odd_mem  [PAIRS];

      always_ff @(posedge clk) begin
         if (tab_we[ch] && !wr_odd) begin
            even_mem[wr_pair] <= tab_val[ch];
         end
      end

      always_ff @(posedge clk) begin
         if (tab_we[ch] && wr_odd) begin
            odd_mem[wr_pair] <= tab_val[ch];
         end
      end

      assign rd_even[ch] = even_mem[rd_pair[ch]];
      assign rd_odd[ch]  = odd_mem[rd_pair[ch]];
   end
endmodule

// File: rtl/gamma_lut_pipe.sv
module gamma_lut_pipe
   import gamma_lut_pkg::*;
#(
   parameter int PIX_W   = 12,
   parameter int IDX_W   = 10,
   parameter int WIDE_W  = 12,
   parameter bit DIFF_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [NUM_CH-1:0][PIX_W-1:0]  in_pix,
   output logic [NUM_CH-1:0][IDX_W-2:0]  rd_pair,
   input  logic [NUM_CH-1:0][WIDE_W-1:0] rd_even,
   input  logic [NUM_CH-1:0][WIDE_W-1:0] rd_odd,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [NUM_CH-1:0][WIDE_W-1:0] out_pix
);
   localparam int LSB    = PIX_W - IDX_W;
   localparam int PAIR_W = IDX_W - 1;

   logic                          advance;
   logic [NUM_CH-1:0]             odd_now;
   logic                          v1;
   logic [NUM_CH-1:0][WIDE_W-1:0] e1;
   logic [NUM_CH-1:0][WIDE_W-1:0] o1;
   logic [NUM_CH-1:0]             p1;
   logic [NUM_CH-1:0][WIDE_W-1:0] recon;

   assign advance  = !out_valid || out_ready;
   assign in_ready = advance;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      assign rd_pair[ch] = in_pix[ch][PIX_W-1 -: PAIR_W];
      assign odd_now[ch] = in_pix[ch][LSB];

      if (DIFF_EN) begin : g_diff
         assign recon[ch] = p1[ch] ? (e1[ch] + o1[ch]) : e1[ch];
      end else begin : g_abs
         assign recon[ch] = p1[ch] ? o1[ch] : e1[ch];
      end
   end

   if (LSB > 0) begin : g_drop
      logic unused_low;
      always_comb begin
         unused_low = 1'b0;
         for (int ch = 0; ch < NUM_CH; ch++) begin
            unused_low = unused_low ^ (^in_pix[ch][LSB-1:0]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1        <= 1'b0;
         out_valid <= 1'b0;
      end else if (advance) begin
         v1        <= in_valid;
         out_valid <= v1;
      end
   end

   always_ff @(posedge clk) begin
      if (advance) begin
         e1      <= rd_even;
         o1      <= rd_odd;
         p1      <= odd_now;
         out_pix <= recon;
      end
   end
endmodule

// File: rtl/gamma_lut_engine.sv
module gamma_lut_engine
   import gamma_lut_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 32,
   parameter int PIX_W        = 12,
   parameter int IDX_W        = 10,
   parameter int BANK_ENTRIES = 256,
   parameter int WIDE_W       = 12,
   parameter int NARROW_W     = 10,
   parameter bit DIFF_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PIX_W-1:0]  in_r,
   input  logic [PIX_W-1:0]  in_g,
   input  logic [PIX_W-1:0]  in_b,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WIDE_W-1:0] out_r,
   output logic [WIDE_W-1:0] out_g,
   output logic [WIDE_W-1:0] out_b
);
   localparam int OFS_W     = $clog2(BANK_ENTRIES);
   localparam int BANK_W    = IDX_W - OFS_W;
   localparam int WIN_BYTES = BANK_ENTRIES * 4;

   if (BANK_ENTRIES != (1 << OFS_W)) begin : g_chk_bank_pow2
      $error("BANK_ENTRIES must be a power of two");
   end
   if (BANK_W < 1) begin : g_chk_bank_bits
      $error("IDX_W must leave at least one bank select bit");
   end
   if (PIX_W < IDX_W) begin : g_chk_pix
      $error("PIX_W must be at least IDX_W");
   end
   if (WIDE_W <= NARROW_W) begin : g_chk_fmt
      $error("WIDE_W must exceed NARROW_W");
   end
   if ((NUM_CH * NARROW_W > DATA_W) || (2 * WIDE_W > DATA_W) || (BANK_W + 1 > DATA_W)) begin : g_chk_data
      $error("DATA_W too narrow for the table layouts");
   end
   if ((ADDR_W > 31) || (longint'(SEC_WIN_OFS) + WIN_BYTES > (longint'(1) << ADDR_W))) begin : g_chk_addr
      $error("ADDR_W cannot reach the second window");
   end
   if (longint'(PRI_WIN_OFS) + WIN_BYTES > longint'(SEC_WIN_OFS)) begin : g_chk_overlap
      $error("table windows overlap");
   end

   logic [NUM_CH-1:0]             tab_we;
   logic [IDX_W-1:0]              tab_addr;
   logic [NUM_CH-1:0][WIDE_W-1:0] tab_val;
   logic [NUM_CH-1:0][IDX_W-2:0]  rd_pair;
   logic [NUM_CH-1:0][WIDE_W-1:0] rd_even;
   logic [NUM_CH-1:0][WIDE_W-1:0] rd_odd;
   logic [NUM_CH-1:0][PIX_W-1:0]  in_pix;
   logic [NUM_CH-1:0][WIDE_W-1:0] out_pix;

   assign in_pix[CH_R] = in_r;
   assign in_pix[CH_G] = in_g;
   assign in_pix[CH_B] = in_b;
   assign out_r = out_pix[CH_R];
   assign out_g = out_pix[CH_G];
   assign out_b = out_pix[CH_B];

   gamma_lut_regs #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .IDX_W       (IDX_W),
      .BANK_ENTRIES(BANK_ENTRIES),
      .WIDE_W      (WIDE_W),
      .NARROW_W    (NARROW_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .tab_we  (tab_we),
      .tab_addr(tab_addr),
      .tab_val (tab_val)
   );

   gamma_lut_store #(
      .IDX_W (IDX_W),
      .WIDE_W(WIDE_W)
   ) u_store (
      .clk     (clk),
      .tab_we  (tab_we),
      .tab_addr(tab_addr),
      .tab_val (tab_val),
      .rd_pair (rd_pair),
      .rd_even (rd_even),
      .rd_odd  (rd_odd)
   );

   gamma_lut_pipe #(
      .PIX_W  (PIX_W),
      .IDX_W  (IDX_W),
      .WIDE_W (WIDE_W),
      .DIFF_EN(DIFF_EN)
   ) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_pix   (in_pix),
      .rd_pair  (rd_pair),
      .rd_even  (rd_even),
      .rd_odd   (rd_odd),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_pix  (out_pix)
   );
endmodule

// File: rtl/gamma_lut_engine_chk.sv
module gamma_lut_engine_chk #(
   parameter int OUT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_r,
   input logic [OUT_W-1:0] out_g,
   input logic [OUT_W-1:0] out_b
);
   logic [1:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc <= 2'd0;
      end else if (cyc != 2'd3) begin
         cyc <= cyc + 2'd1;
      end
   end

   // R1: reset clears the output valid
   p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

   // R9: no intake while the output is held
   p_no_intake_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   // R9: an empty output stage always takes a pixel
   p_empty_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   // R9: a refused pixel is held unchanged
   p_hold_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b));

   // R8: accepted pixel appears two cycles later when the pipe moved
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3) && $past(in_valid && in_ready, 2) && $past(in_ready) |-> out_valid);
endmodule

bind gamma_lut_engine gamma_lut_engine_chk #(.OUT_W(WIDE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_r    (out_r),
   .out_g    (out_g),
   .out_b    (out_b)
);

// File: tb/tb_gamma_lut_engine.sv
module tb_gamma_lut_engine;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 150000;

   logic        clk;
   logic        rst_n;
   logic        wr_en;
   logic [11:0] wr_addr;
   logic [31:0] wr_data;
   logic        in_valid;
   logic        in_ready;
   logic [11:0] in_r, in_g, in_b;
   logic        out_valid;
   logic        out_ready;
   logic [11:0] out_r, out_g, out_b;

   gamma_lut_engine dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_r(in_r), .in_g(in_g), .in_b(in_b),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // behavioural model: table, bank state, two result slots
   int ref_tab [1024][3];
   int ref_bank = 0;
   int ref_split = 0;
   bit m1_v = 0, m2_v = 0;
   int m1_val [3];
   int m2_val [3];
   int m1_tag = 0, m2_tag = 0;
   int cur_tag = 6;

   bit          d_wr = 0;
   logic [11:0] d_addr = '0;
   logic [31:0] d_data = '0;
   bit          d_pv = 0;
   int          d_px [3];
   bit          rdy_rand = 0;
   bit          last_acc = 0;

   task automatic check(int tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int lookup(int comp, int ch);
      int idx;
      idx = (comp >> 2) & 1023;
      if (idx % 2 == 0) return ref_tab[idx][ch];
      return (ref_tab[idx-1][ch] + ref_tab[idx][ch]) & 12'hFFF;
   endfunction

   function automatic void model_write(int a, int unsigned d);
      int e;
      if (a == 32'h100) begin
         ref_bank  = d & 3;
         ref_split = (d >> 2) & 1;
      end else if (a % 4 == 0 && a >= 32'h700 && a < 32'hB00) begin
         e = ref_bank * 256 + (a - 32'h700) / 4;
         if (ref_split != 0) begin
            ref_tab[e][0] = d & 12'hFFF;
            ref_tab[e][1] = (d >> 12) & 12'hFFF;
         end else begin
            ref_tab[e][0] = ((d >> 20) & 10'h3FF) << 2;
            ref_tab[e][1] = ((d >> 10) & 10'h3FF) << 2;
            ref_tab[e][2] = (d & 10'h3FF) << 2;
         end
      end else if (a % 4 == 0 && a >= 32'hB00 && a < 32'hF00 && ref_split != 0) begin
         e = ref_bank * 256 + (a - 32'hB00) / 4;
         ref_tab[e][2] = d & 12'hFFF;
      end
   endfunction

   task automatic step();
      bit adv;
      @(negedge clk);
      check(8, "out_valid", int'(out_valid), int'(m2_v));
      if (m2_v) begin
         check(m2_tag, "out_r", int'(out_r), m2_val[0]);
         check(m2_tag, "out_g", int'(out_g), m2_val[1]);
         check(m2_tag, "out_b", int'(out_b), m2_val[2]);
      end
      wr_en     = d_wr;
      wr_addr   = d_addr;
      wr_data   = d_data;
      in_valid  = d_pv;
      in_r      = 12'(d_px[0]);
      in_g      = 12'(d_px[1]);
      in_b      = 12'(d_px[2]);
      out_ready = rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
      #1;
      adv = !m2_v || out_ready;
      check(9, "in_ready", int'(in_ready), int'(adv));
      last_acc = d_pv && adv;
      if (adv) begin
         m2_v   = m1_v;
         m2_val = m1_val;
         m2_tag = m1_tag;
         m1_v   = last_acc;
         m1_tag = cur_tag;
         if (last_acc) begin
            for (int ch = 0; ch < 3; ch++) m1_val[ch] = lookup(d_px[ch], ch);
         end
      end
      if (d_wr) model_write(int'(d_addr), d_data);
   endtask

   task automatic reg_write(int a, int unsigned d);
      d_wr = 1; d_addr = 12'(a); d_data = d;
      step();
      d_wr = 0;
   endtask

   task automatic send_px(int r, int g, int b);
      d_pv = 1; d_px[0] = r; d_px[1] = g; d_px[2] = b;
      do step(); while (!last_acc);
      d_pv = 0;
   endtask

   task automatic drain();
      bit keep;
      keep = rdy_rand;
      rdy_rand = 0;
      while (m1_v || m2_v) step();
      step();
      rdy_rand = keep;
   endtask

   initial begin
      for (int e = 0; e < 1024; e++)
         for (int ch = 0; ch < 3; ch++) ref_tab[e][ch] = 0;
      for (int ch = 0; ch < 3; ch++) begin
         m1_val[ch] = 0; m2_val[ch] = 0; d_px[ch] = 0;
      end
      rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
      in_valid = 0; in_r = '0; in_g = '0; in_b = '0; out_ready = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: idle outputs after reset
      check(1, "out_valid after reset", int'(out_valid), 0);
      check(1, "in_ready after reset", int'(in_ready), 1);

      // R1: default bank 0 and packed layout; R6 low bits of the component ignored
      cur_tag = 1;
      reg_write(32'h700 + 4*4, {2'b00, 10'h155, 10'h2AA, 10'h0F0});
      send_px(16 + 3, 16 + 1, 16 + 2);
      drain();

      // R2, R3: fill every bank in the packed layout
      for (int bk = 0; bk < 4; bk++) begin
         reg_write(32'h100, bk);
         for (int i = 0; i < 256; i++) reg_write(32'h700 + 4*i, $urandom);
      end
      cur_tag = 3;
      rdy_rand = 1;
      for (int k = 0; k < 300; k++) send_px($urandom % 4096, $urandom % 4096, $urandom % 4096);
      // R6 even index, R7 odd index at the top of the table
      cur_tag = 6;
      send_px(1022*4, 1022*4 + 3, 1022*4 + 1);
      cur_tag = 7;
      send_px(1023*4, 1023*4 + 2, 1021*4);
      drain();

      // R4: split layout, both windows, all banks
      rdy_rand = 0;
      for (int bk = 0; bk < 4; bk++) begin
         reg_write(32'h100, 4 | bk);
         for (int i = 0; i < 256; i++) begin
            reg_write(32'h700 + 4*i, $urandom);
            reg_write(32'hB00 + 4*i, $urandom);
         end
      end
      cur_tag = 2;
      rdy_rand = 1;
      for (int k = 0; k < 300; k++) send_px($urandom % 4096, $urandom % 4096, $urandom % 4096);
      drain();
      // R4: first window leaves blue, second leaves red and green
      cur_tag = 4;
      reg_write(32'h100, 4 | 3);
      reg_write(32'h700 + 4*10, 32'h00ABC123);
      reg_write(32'hB00 + 4*11, 32'h00000FED);
      send_px((768+10)*4, (768+10)*4, (768+10)*4);
      send_px((768+11)*4, (768+11)*4, (768+11)*4);
      drain();

      // R5: second window ignored in the packed layout
      cur_tag = 5;
      reg_write(32'h100, 0);
      reg_write(32'hB00 + 4*20, 32'h00000ABC);
      reg_write(32'hB00 + 4*21, 32'h00000123);
      send_px(20*4, 20*4, 20*4);
      send_px(21*4, 21*4, 21*4);
      drain();

      // R11: stray offsets and misaligned writes
      cur_tag = 11;
      reg_write(32'h000, 32'hFFFFFFFF);
      reg_write(32'h104, 32'h00000007);
      reg_write(32'h101, 32'h00000007);
      reg_write(32'h701, 32'hFFFFFFFF);
      reg_write(32'hB02, 32'hFFFFFFFF);
      reg_write(32'hF00, 32'hFFFFFFFF);
      reg_write(32'hFFC, 32'hFFFFFFFF);
      send_px(0, 4, 8);
      reg_write(32'h700 + 4*2, {2'b00, 10'h3FF, 10'h001, 10'h200});
      send_px(2*4, 2*4, 2*4);
      drain();

      // R10: write and lookup of one entry in the same cycle
      cur_tag = 10;
      reg_write(32'h700 + 4*40, {2'b00, 10'h111, 10'h222, 10'h333});
      d_wr = 1; d_addr = 12'(32'h700 + 4*40); d_data = {2'b00, 10'h0AA, 10'h0BB, 10'h0CC};
      d_pv = 1; d_px[0] = 40*4; d_px[1] = 40*4; d_px[2] = 40*4;
      step();
      d_wr = 0; d_pv = 0;
      check(10, "same-cycle accept", int'(last_acc), 1);
      send_px(40*4, 40*4, 40*4);
      drain();

      // R7: increment sum wraps modulo 4096
      cur_tag = 7;
      reg_write(32'h100, 4 | 1);
      reg_write(32'h700 + 4*6, 32'h00800F00);
      reg_write(32'hB00 + 4*6, 32'h00000FFF);
      reg_write(32'h700 + 4*7, 32'h00900200);
      reg_write(32'hB00 + 4*7, 32'h00000001);
      send_px((256+7)*4, (256+7)*4, (256+7)*4);
      drain();

      // R8, R9: back-to-back stream against a stalling consumer
      cur_tag = 8;
      rdy_rand = 1;
      for (int k = 0; k < 400; k++) send_px($urandom % 4096, $urandom % 4096, $urandom % 4096);
      drain();

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule